// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

This block is a free-running 32-bit up-counter behind a small memory-mapped register file. Software programs a control word, a reload value and a compare value, then starts the counter. The counter advances either on every clock or at a power-of-two divided rate. When it rolls past its all-ones value it either reloads itself from the reload register and keeps running, or wraps to zero and stops. A write to a dedicated strobe address forces an immediate reload, whatever data is written.

Two events, rollover and compare hit, set sticky status flags that software clears by writing ones. The flags are masked by an enable register and ORed into one interrupt line. The same events can drive a timer output pin. The pin either shows a one-clock pulse or flips its level on each qualifying event, around a programmable idle level. The bus port is a single-cycle register access: writes land on the clock edge, and reads return data combinationally in the same cycle.

Top module: `gpt_core`

## Requirements
- R1: After reset, every readable register reads 0, the interrupt line is low and the timer output is low.
- R2: The control word (offset 0x24) keeps bits 14:0 and reads them back, with bits 31:15 read as 0. The reload (0x2C) and compare (0x38) registers keep all 32 bits. The interrupt enable (0x1C) keeps bits 1:0, and a read of the strobe address (0x30) returns 0.
- R3: While control bit 0 (run) is 1 and prescaling is off, the counter (0x28) rises by one on every clock edge, starting with the edge after the edge that sets run. A bus write to the counter takes effect at its edge, in place of the increment.
- R4: Clearing run stops the counter, and the counter holds its value.
- R5: With control bit 5 set, the counter advances once every 2^(P+1) clocks, where P is control bits 4:2. With bit 5 clear, P has no effect.
- R6: Any write to offset 0x30, with any data, copies the reload register into the counter at that edge.
- R7: When a tick occurs at count 0xFFFFFFFF and control bit 1 (auto-reload) is set, the counter takes the reload value, status bit 1 (0x18) is set at the same edge, and counting continues.
- R8: When a tick occurs at count 0xFFFFFFFF and auto-reload is clear, the counter becomes 0, status bit 1 is set and run is cleared by hardware.
- R9: With control bit 6 set, a tick that makes the counter equal the compare register sets status bit 0 at that edge. With bit 6 clear, no compare hit is recorded.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An event at the same edge wins over the clear.
- R11: The interrupt line is high exactly when some status bit and its enable bit are both 1.
- R12: Control bits 11:10 choose which events drive the output: 01 selects rollover only, 10 selects rollover and compare hit, and other codes select none. With control bit 12 clear, the output equals control bit 7 inverted for one clock, beginning at the edge that records a qualifying event, and equals control bit 7 otherwise.
- R13: With control bit 12 set, each qualifying event inverts the output relative to control bit 7. Clearing bit 12 returns the output to control bit 7.
- R14: Control bits 14, 13 and 9:8 are stored only. They do not change counting, events or the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| irq_o | output | 1 | Masked OR of the status flags |
| tout_o | output | 1 | Timer output pin |

## Verification
A register write is visible to a read in the cycle after the edge that captures it. The counter first steps at the edge following the run write. Rollover, compare hit, their status flags, the hardware run clear and the output pulse all appear together at the edge where the counter reaches the critical value. The reference model in the bench advances on the same rising edges from the same bus inputs. The interrupt line, the output pin and every read are compared at the falling edge, where all of these results have settled. Directed checks place the strobes so that coincidences fall on known edges: a clear landing on a compare hit, and the edge where rollover stops the counter. Rate checks compare two reads taken a fixed number of edges apart.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int ADDR_W  = 8;
    localparam int CTRL_W  = 15;
    localparam int PTV_W   = 3;

    // register offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h38;

    // control word bit positions
    localparam int C_RUN    = 0;
    localparam int C_AUTO   = 1;
    localparam int C_PTV_LO = 2;
    localparam int C_PRE    = 5;
    localparam int C_CMP    = 6;
    localparam int C_DFLT   = 7;
    localparam int C_TRG_LO = 10;
    localparam int C_TOG    = 12;

    // status bit positions
    localparam int S_HIT = 0;
    localparam int S_OVF = 1;

    typedef enum logic [1:0] {
        TRG_NONE = 2'b00,
        TRG_OVF  = 2'b01,
        TRG_BOTH = 2'b10,
        TRG_RSVD = 2'b11
    } trg_mode_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
    import gpt_pkg::*;
#(
    parameter int SEL_W = PTV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_en,
    input  logic [SEL_W-1:0] ptv,
    output logic             tick_o
);
    localparam int DIV_W = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] lim;

    always_comb begin
        span   = {{DIV_W{1'b0}}, 1'b1} << ({1'b0, ptv} + (SEL_W+1)'(1));
        lim    = span[DIV_W-1:0] - DIV_W'(1);
        tick_o = run && (!pre_en || (st_q.div == lim));
        st_d   = st_q;
        if (!run || !pre_en || tick_o) st_d.div = '0;
        else                           st_d.div = st_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a divided tick is never followed by another while division stays on
    assert_prescaled_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && tick_o) |=> (!tick_o || !pre_en));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_val,
    input  logic             sw_trig,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        ovf_o   = tick && (&st_q.cnt);
        stepped = st_q.cnt;
        if (tick) begin
            if (ovf_o) stepped = auto_rl ? load_val : '0;
            else       stepped = st_q.cnt + CNT_W'(1);
        end
        hit_o = tick && cmp_en && (stepped == match_val);
        st_d  = st_q;
        if (sw_wr)        st_d.cnt = sw_val;
        else if (sw_trig) st_d.cnt = load_val;
        else              st_d.cnt = stepped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ovf_o && !sw_wr && !sw_trig) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    assert_wrap_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !sw_wr && !sw_trig) |=> (cnt_o == '0 || cnt_o == $past(load_val)));

    assert_trigger_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig && !sw_wr) |=> (cnt_o == $past(load_val)));
endmodule

// File: rtl/gpt_outgen.sv
module gpt_outgen
    import gpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] trg,
    input  logic       tog_mode,
    input  logic       dflt,
    input  logic       ovf_ev,
    input  logic       hit_ev,
    output logic       tout_o
);
    typedef struct packed {
        logic pulse;
        logic tog;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       ev;

    always_comb begin
        case (trg_mode_e'(trg))
            TRG_OVF:  ev = ovf_ev;
            TRG_BOTH: ev = ovf_ev || hit_ev;
            default:  ev = 1'b0;
        endcase
        st_d       = st_q;
        st_d.pulse = ev;
        st_d.tog   = tog_mode ? (st_q.tog ^ ev) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tout_o = dflt ^ (tog_mode ? st_q.tog : st_q.pulse);

    assert_toggle_flip_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_mode && ev) |=> (st_q.tog != $past(st_q.tog)));

    assert_pulse_one_clock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && !ev) |=> !st_q.pulse);
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              tout_o
);
    localparam int NFLAG = 2;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  match;
        logic [NFLAG-1:0]  stat;
        logic [NFLAG-1:0]  ien;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             wr_en, rd_en;
    logic             tick, ovf_ev, hit_ev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    gpt_prescaler #(.SEL_W(PTV_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (regs_q.ctrl[C_RUN]),
        .pre_en (regs_q.ctrl[C_PRE]),
        .ptv    (regs_q.ctrl[C_PTV_LO +: PTV_W]),
        .tick_o (tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .auto_rl   (regs_q.ctrl[C_AUTO]),
        .cmp_en    (regs_q.ctrl[C_CMP]),
        .load_val  (regs_q.load),
        .match_val (regs_q.match),
        .sw_wr     (wr_en && bus_addr == OFS_CNT),
        .sw_val    (bus_wdata),
        .sw_trig   (wr_en && bus_addr == OFS_TRIG),
        .cnt_o     (cnt),
        .ovf_o     (ovf_ev),
        .hit_o     (hit_ev)
    );

    gpt_outgen u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .trg      (regs_q.ctrl[C_TRG_LO +: 2]),
        .tog_mode (regs_q.ctrl[C_TOG]),
        .dflt     (regs_q.ctrl[C_DFLT]),
        .ovf_ev   (ovf_ev),
        .hit_ev   (hit_ev),
        .tout_o   (tout_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (ovf_ev && !regs_q.ctrl[C_AUTO]) regs_d.ctrl[C_RUN] = 1'b0;
        if (wr_en) begin
            case (bus_addr)
                OFS_CTRL:  regs_d.ctrl  = bus_wdata[CTRL_W-1:0];
                OFS_LOAD:  regs_d.load  = bus_wdata;
                OFS_MATCH: regs_d.match = bus_wdata;
                OFS_STAT:  regs_d.stat  = regs_q.stat & ~bus_wdata[NFLAG-1:0];
                OFS_IEN:   regs_d.ien   = bus_wdata[NFLAG-1:0];
                default:   ;
            endcase
        end
        regs_d.stat[S_OVF] = regs_d.stat[S_OVF] | ovf_ev;
        regs_d.stat[S_HIT] = regs_d.stat[S_HIT] | hit_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  rd_mux = CNT_W'(regs_q.ctrl);
            OFS_CNT:   rd_mux = cnt;
            OFS_LOAD:  rd_mux = regs_q.load;
            OFS_MATCH: rd_mux = regs_q.match;
            OFS_STAT:  rd_mux = CNT_W'(regs_q.stat);
            OFS_IEN:   rd_mux = CNT_W'(regs_q.ien);
            default:   rd_mux = '0;
        endcase
        bus_rdata = rd_en ? rd_mux : '0;
    end

    assign irq_o = |(regs_q.stat & regs_q.ien);

    assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> regs_q.stat[S_OVF]);

    assert_hit_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ev |=> regs_q.stat[S_HIT]);

    assert_run_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev && !regs_q.ctrl[C_AUTO] && !(wr_en && bus_addr == OFS_CTRL))
        |=> !regs_q.ctrl[C_RUN]);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.stat[S_OVF] && !(wr_en && bus_addr == OFS_STAT)) |=> regs_q.stat[S_OVF]);
endmodule

// File: tb/test_gpt_core.sv
module test_gpt_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, tout;

    int vectors = 0;
    int fails = 0;

    gpt_core i_gpt_core (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .tout_o(tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [14:0] m_ctrl;
    logic [31:0] m_cnt, m_load, m_match;
    logic [1:0]  m_stat, m_ien;
    int          m_psc;
    logic        m_pulse, m_tog;
    logic        t_tick, t_ovf, t_hit, t_ev;
    logic [31:0] t_cnt, t_load, t_match;
    logic [14:0] t_ctrl;
    logic [1:0]  t_stat, t_ien;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_load = '0; m_match = '0;
            m_stat = '0; m_ien = '0; m_psc = 0; m_pulse = 0; m_tog = 0;
        end else begin
            t_tick = 1'b0;
            if (m_ctrl[0]) t_tick = m_ctrl[5] ? (m_psc == (2 << m_ctrl[4:2]) - 1) : 1'b1;
            t_ovf = t_tick && (m_cnt == 32'hFFFF_FFFF);
            t_cnt = m_cnt;
            if (t_tick) t_cnt = t_ovf ? (m_ctrl[1] ? m_load : 32'd0) : m_cnt + 1;
            t_hit = t_tick && m_ctrl[6] && (t_cnt == m_match);
            t_ev  = (m_ctrl[11:10] == 2'b01 && t_ovf) ||
                    (m_ctrl[11:10] == 2'b10 && (t_ovf || t_hit));
            t_ctrl = m_ctrl;
            if (t_ovf && !m_ctrl[1]) t_ctrl[0] = 1'b0;
            t_load = m_load; t_match = m_match; t_stat = m_stat; t_ien = m_ien;
            if (sel && wr) begin
                case (addr)
                    8'h24: t_ctrl  = wdata[14:0];
                    8'h28: t_cnt   = wdata;
                    8'h2C: t_load  = wdata;
                    8'h30: t_cnt   = m_load;
                    8'h38: t_match = wdata;
                    8'h18: t_stat  = m_stat & ~wdata[1:0];
                    8'h1C: t_ien   = wdata[1:0];
                    default: ;
                endcase
            end
            t_stat = t_stat | {t_ovf, t_hit};
            m_psc   = (!m_ctrl[0] || !m_ctrl[5] || t_tick) ? 0 : m_psc + 1;
            m_tog   = m_ctrl[12] ? (m_tog ^ t_ev) : 1'b0;
            m_pulse = t_ev;
            m_ctrl = t_ctrl; m_cnt = t_cnt; m_load = t_load; m_match = t_match;
            m_stat = t_stat; m_ien = t_ien;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h24:   return {17'd0, m_ctrl};
            8'h28:   return m_cnt;
            8'h2C:   return m_load;
            8'h38:   return m_match;
            8'h18:   return {30'd0, m_stat};
            8'h1C:   return {30'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every cycle: interrupt line and output pin against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R11 irq line", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
            check("R12 R13 timer output", {31'd0, tout},
                  {31'd0, m_ctrl[7] ^ (m_ctrl[12] ? m_tog : m_pulse)});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input string tag, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        check(tag, d, model_read(a));
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    logic [31:0] v, v2;
    int          n;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tout", {31'd0, tout}, 32'd0);
        bus_read("R1 ctrl", 8'h24, v);  check("R1 ctrl literal", v, 0);
        bus_read("R1 cnt", 8'h28, v);   check("R1 cnt literal", v, 0);
        bus_read("R1 load", 8'h2C, v);  check("R1 load literal", v, 0);
        bus_read("R1 stat", 8'h18, v);  check("R1 stat literal", v, 0);

        // R2 readback
        bus_write(8'h24, 32'hFFFF_FFFF & ~32'h1);
        bus_read("R2 ctrl", 8'h24, v);  check("R2 ctrl bits", v, 32'h7FFE);
        bus_write(8'h24, 32'h0);
        bus_write(8'h2C, 32'hA5A5_1234);
        bus_read("R2 load", 8'h2C, v);  check("R2 load bits", v, 32'hA5A5_1234);
        bus_write(8'h38, 32'h0BAD_F00D);
        bus_read("R2 match", 8'h38, v); check("R2 match bits", v, 32'h0BAD_F00D);
        bus_write(8'h1C, 32'hF);
        bus_read("R2 ien", 8'h1C, v);   check("R2 ien bits", v, 32'h3);
        bus_read("R2 strobe", 8'h30, v); check("R2 strobe reads 0", v, 0);
        bus_write(8'h1C, 32'h0);

        // R3 counting
        bus_write(8'h28, 32'd100);
        bus_write(8'h24, 32'h1);
        bus_read("R3 cnt first", 8'h28, v); check("R3 cnt at start", v, 32'd100);
        bus_read("R3 cnt next", 8'h28, v);  check("R3 cnt steps", v, 32'd101);
        bus_write(8'h28, 32'd500);
        bus_read("R3 cnt written", 8'h28, v); check("R3 write beats step", v, 32'd500);

        // R4 stop holds
        bus_write(8'h24, 32'h0);
        bus_read("R4 held a", 8'h28, v);
        idle(10);
        bus_read("R4 held b", 8'h28, v2); check("R4 held value", v2, v);

        // R5 prescaler: P=1 -> /4
        bus_write(8'h28, 32'd0);
        bus_write(8'h24, 32'h25);
        idle(8);
        bus_read("R5 a", 8'h28, v); idle(15);
        bus_read("R5 b", 8'h28, v2); check("R5 divide by 4", v2 - v, 32'd4);
        // P=7 with prescaler off -> every clock
        bus_write(8'h24, 32'h1D);
        bus_read("R5 c", 8'h28, v); idle(15);
        bus_read("R5 d", 8'h28, v2); check("R5 field ignored when off", v2 - v, 32'd16);
        // P=7 with prescaler on -> /256
        bus_write(8'h24, 32'h3D);
        idle(300);
        bus_read("R5 e", 8'h28, v); idle(255);
        bus_read("R5 f", 8'h28, v2); check("R5 divide by 256", v2 - v, 32'd1);

        // R6 trigger
        bus_write(8'h24, 32'h0);
        bus_write(8'h2C, 32'h1234);
        bus_write(8'h30, 32'hDEAD);
        bus_read("R6 cnt", 8'h28, v); check("R6 reload copy", v, 32'h1234);

        // R7 rollover with auto-reload, R11 irq
        bus_write(8'h2C, 32'h50);
        bus_write(8'h28, 32'hFFFF_FFFD);
        bus_write(8'h1C, 32'h2);
        bus_write(8'h24, 32'h3);
        idle(6);
        bus_read("R7 stat", 8'h18, v); check("R7 ovf flag", v, 32'h2);
        bus_read("R7 cnt", 8'h28, v);
        check("R7 reloaded and running", {31'd0, v > 32'h50 && v < 32'h60}, 32'd1);
        check("R11 irq raised", {31'd0, irq}, 32'd1);
        bus_write(8'h18, 32'h2);
        bus_read("R10 stat clear", 8'h18, v); check("R10 w1c", v, 32'h0);
        check("R11 irq dropped", {31'd0, irq}, 32'd0);

        // R8 rollover without auto-reload
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'hFFFF_FFFE);
        bus_write(8'h24, 32'h1);
        idle(5);
        bus_read("R8 ctrl", 8'h24, v); check("R8 run cleared", v, 32'h0);
        bus_read("R8 cnt", 8'h28, v);  check("R8 wrap to zero", v, 32'h0);
        bus_read("R8 stat", 8'h18, v); check("R8 ovf flag", v, 32'h2);
        bus_write(8'h18, 32'h3);

        // R9 compare
        bus_write(8'h38, 32'h20);
        bus_write(8'h28, 32'h10);
        bus_write(8'h24, 32'h41);
        idle(30);
        bus_read("R9 hit", 8'h18, v); check("R9 hit flag", v, 32'h1);
        bus_write(8'h24, 32'h0);
        bus_write(8'h18, 32'h1);
        bus_write(8'h28, 32'h10);
        bus_write(8'h24, 32'h1);
        idle(30);
        bus_read("R9 no hit", 8'h18, v); check("R9 compare off", v, 32'h0);

        // R10 event beats clear at the same edge
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h1E);
        bus_write(8'h24, 32'h41);
        idle(1);
        bus_write(8'h18, 32'h1);
        bus_read("R10 set wins", 8'h18, v); check("R10 set beats clear", v, 32'h1);
        bus_write(8'h18, 32'h1);

        // R12 pulse, overflow only (compare enabled but not selected)
        bus_write(8'h24, 32'h0);
        bus_write(8'h2C, 32'h0);
        bus_write(8'h38, 32'hFFFF_FFF8);
        bus_write(8'h28, 32'hFFFF_FFF0);
        bus_write(8'h24, 32'h443);
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (tout) n++; end
        check("R12 overflow-only pulses", n, 1);
        // overflow and match
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'hFFFF_FFF0);
        bus_write(8'h24, 32'h843);
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (tout) n++; end
        check("R12 both-event pulses", n, 2);
        // idle level high
        bus_write(8'h24, 32'h80);
        bus_write(8'h28, 32'hFFFF_FFF0);
        bus_write(8'h24, 32'h8C3);
        n = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (!tout) n++; end
        check("R12 inverted pulses", n, 2);

        // R13 toggle
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'hFFFF_FFF0);
        bus_write(8'h24, 32'h1843);
        n = 0; v = {31'd0, tout};
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tout !== v[0]) n++;
            v = {31'd0, tout};
        end
        check("R13 level flips", n, 2);
        bus_write(8'h24, 32'h1443);
        bus_write(8'h28, 32'hFFFF_FFF6);
        idle(12);
        bus_write(8'h24, 32'h0);
        @(negedge clk);
        check("R13 cleared to idle level", {31'd0, tout}, 32'd0);
        bus_write(8'h18, 32'h3);

        // R14 stored-only bits
        bus_write(8'h28, 32'd0);
        bus_write(8'h24, 32'h6301);
        bus_read("R14 a", 8'h28, v); idle(15);
        bus_read("R14 b", 8'h28, v2); check("R14 rate unchanged", v2 - v, 32'd16);
        check("R14 output unchanged", {31'd0, tout}, 32'd0);
        bus_write(8'h24, 32'h0);

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule